// File: doc/BRIEF.md
# Double-Buffered Period-Match PWM Generator

This block drives one pulse-width-modulated output from a free-running time base. An 8-bit period timer is extended below by a 2-bit fine counter, which gives a 10-bit time base. A 10-bit duty value is compared against that time base. The fine counter advances once per prescaled tick, and the prescaler divides the input clock by 1, 4 or 16. One period spans (period + 1) × 4 × ratio input clocks. The output is high for duty × ratio input clocks, or for the whole period when the duty value does not fit in it.

Software writes three registers through a small write port: the period, the upper eight duty bits, and a control register. The control register holds the two lower duty bits, a mode field and the prescale select. Duty writes go into a holding value that the generator does not use directly. At each period match that value is copied into a shadow register, and the comparator and output latch work only from the shadow. A period therefore never sees a half-written duty value. The shadow contents appear on a read-only output. While the mode field does not select PWM, the output is held low and the time base is held at zero.

Top module: `pwm_gen`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `pwm_out` is 0, `time_base` is 0 and `duty_active` is 0.
- R2: A write with `reg_sel`=0 sets the period P. `reg_sel`=1 sets duty bits [9:2]. `reg_sel`=2 sets the control register: `reg_wdata[1:0]` are duty bits [1:0], `reg_wdata[3:2]` is the mode (2'b11 runs PWM, any other value is off), and `reg_wdata[5:4]` selects the prescale (00 divides by 1, 01 by 4, 10 and 11 by 16).
- R3: `time_base` is {timer, fine}. While running, it advances by one on every prescaled tick, so a value is held for exactly ratio clocks.
- R4: A period match happens at a tick where the timer equals P and fine is 3. `time_base` then returns to 0, so a period lasts exactly (P+1)·4·ratio clocks.
- R5: The 10-bit duty value is copied into `duty_active` only at a period match. A duty write made during a period, or on the same clock as the match, does not change the duty used in that period.
- R6: At a period match `pwm_out` is set if the newly latched duty is nonzero. A zero duty keeps `pwm_out` low for the whole period.
- R7: `pwm_out` is cleared on the tick where `time_base` reaches `duty_active`, so the high time per period is D·ratio clocks when D < (P+1)·4.
- R8: When D ≥ (P+1)·4, `pwm_out` stays high for the whole period.
- R9: One clock after the mode leaves PWM, `pwm_out` is 0 and `time_base` is 0. After PWM is selected again, `pwm_out` stays low until the first period match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| pwm_out | output | 1 | PWM output latch |
| duty_active | output | 10 | Read-only shadow of the duty value in use |
| time_base | output | 10 | Current {timer, fine} time base |

## Verification
Three events can fall on the same edge: loading the shadow, setting the output at the period start, and clearing it on a duty match. A zero duty lines the clear up with the set, and the clear must win. The bench also lands a duty write on the exact edge of a period match; `duty_active` must take the old value there and the new one only at the following match. A sweep of every duty value from 0 to (P+1)·4+1, over several periods and all prescale ratios, places the clear point both inside and past the period boundary. High time, period length and the time-base progression are each compared against the arithmetic formulas.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;

    localparam int TMR_W  = 8;
    localparam int FINE_W = 2;
    localparam int PS_W   = 4;

    typedef enum logic [1:0] {
        SEL_PERIOD  = 2'd0,
        SEL_DUTY_HI = 2'd1,
        SEL_CTRL    = 2'd2,
        SEL_SPARE   = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_RSV1 = 2'b01,
        MODE_RSV2 = 2'b10,
        MODE_PWM  = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        PS_DIV1   = 2'b00,
        PS_DIV4   = 2'b01,
        PS_DIV16  = 2'b10,
        PS_DIV16B = 2'b11
    } ps_e;

    // Control register layout, packed from the top bit down.
    typedef struct packed {
        ps_e               ps;
        mode_e             mode;
        logic [FINE_W-1:0] duty_lo;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // Last prescaler count before a tick for the selected ratio.
    function automatic logic [PS_W-1:0] ps_last(input ps_e p);
        case (p)
            PS_DIV1: ps_last = PS_W'(0);
            PS_DIV4: ps_last = PS_W'(3);
            default: ps_last = PS_W'(15);
        endcase
    endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_gen_pkg::*;
#(
    parameter int TMR_W_P  = TMR_W,
    parameter int FINE_W_P = FINE_W,
    localparam int DUTY_W  = TMR_W_P + FINE_W_P
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic [1:0]          sel,
    input  logic [TMR_W_P-1:0]  wdata,
    output logic [TMR_W_P-1:0]  period,
    output logic [DUTY_W-1:0]   duty_buf,
    output ctrl_t               ctrl
);

    logic [TMR_W_P-1:0] duty_hi;
    reg_sel_e           sel_e;

    assign sel_e = reg_sel_e'(sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            period  <= '0;
            duty_hi <= '0;
            ctrl    <= '0;
        end else if (wr) begin
            case (sel_e)
                SEL_PERIOD:  period  <= wdata;
                SEL_DUTY_HI: duty_hi <= wdata;
                SEL_CTRL:    ctrl    <= ctrl_t'(wdata[CTRL_W-1:0]);
                default: ;
            endcase
        end
    end

    assign duty_buf = {duty_hi, ctrl.duty_lo};

    // R2: a register changes only through a write strobe
    assert_regs_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !wr |=> ($stable(period) && $stable(duty_buf) && $stable(ctrl)));

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_gen_pkg::*;
#(
    parameter int TMR_W_P  = TMR_W,
    parameter int FINE_W_P = FINE_W,
    parameter int PS_W_P   = PS_W,
    localparam int DUTY_W  = TMR_W_P + FINE_W_P
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  ps_e                 ps,
    input  logic [TMR_W_P-1:0]  period,
    output logic [DUTY_W-1:0]   base,
    output logic [DUTY_W-1:0]   next_base,
    output logic                tick,
    output logic                wrap
);

    logic [PS_W_P-1:0]   pre_cnt;
    logic [PS_W_P-1:0]   pre_last;
    logic [TMR_W_P-1:0]  tmr;
    logic [FINE_W_P-1:0] fine;
    logic                fine_top;

    assign pre_last = PS_W_P'(ps_last(ps));
    assign tick     = en && (pre_cnt >= pre_last);
    assign fine_top = &fine;
    assign wrap     = tick && fine_top && (tmr == period);
    assign base     = {tmr, fine};

    always_ff @(posedge clk) begin
        if (rst || !en)
            pre_cnt <= '0;
        else if (pre_cnt >= pre_last)
            pre_cnt <= '0;
        else
            pre_cnt <= pre_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || !en)
            fine <= '0;
        else if (tick)
            fine <= fine + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || !en)
            tmr <= '0;
        else if (tick && fine_top)
            tmr <= (tmr == period) ? '0 : tmr + 1'b1;
    end

    always_comb begin
        if (!tick)
            next_base = base;
        else if (wrap)
            next_base = '0;
        else
            next_base = base + {{(DUTY_W-1){1'b0}}, 1'b1};
    end

    // R4: a period match returns the time base to zero
    assert_wrap_to_zero_R4: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (base == '0));

    // R3: the fine count moves only on a prescaled tick
    assert_fine_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (en && !tick) |=> $stable(fine));

    // R9: with the mode off the time base sits at zero
    assert_off_base_R9: assert property (@(posedge clk) disable iff (rst)
        !en |=> (base == '0));

endmodule

// File: rtl/pwm_outlatch.sv
module pwm_outlatch
    import pwm_gen_pkg::*;
#(
    parameter int DUTY_W = TMR_W + FINE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               tick,
    input  logic               wrap,
    input  logic [DUTY_W-1:0]  next_base,
    input  logic [DUTY_W-1:0]  duty_buf,
    output logic [DUTY_W-1:0]  shadow,
    output logic               pwm_q
);

    logic duty_nz;
    logic hit;

    assign duty_nz = |duty_buf;
    assign hit     = tick && (next_base == shadow);

    always_ff @(posedge clk) begin
        if (rst)
            shadow <= '0;
        else if (wrap)
            shadow <= duty_buf;
    end

    // Period start has priority; its set is already suppressed for zero duty.
    always_ff @(posedge clk) begin
        if (rst || !en)
            pwm_q <= 1'b0;
        else if (wrap)
            pwm_q <= duty_nz;
        else if (hit)
            pwm_q <= 1'b0;
    end

    // R5: the shadow changes only at a period match
    assert_shadow_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(shadow));

    // R6: a rising output only follows a period match
    assert_set_at_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(pwm_q) |-> $past(wrap));

    // R6: a zero duty period starts low
    assert_zero_duty_R6: assert property (@(posedge clk) disable iff (rst)
        (wrap && !duty_nz) |=> !pwm_q);

    // R7: a falling output follows a tick or a disable
    assert_clear_on_tick_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(pwm_q) |-> ($past(tick) || !$past(en)));

    // R9: the mode being off forces the output low
    assert_off_low_R9: assert property (@(posedge clk) disable iff (rst)
        !en |=> !pwm_q);

endmodule

// File: rtl/pwm_gen.sv
module pwm_gen
    import pwm_gen_pkg::*;
#(
    parameter int TMR_W_P  = TMR_W,
    parameter int FINE_W_P = FINE_W,
    parameter int PS_W_P   = PS_W,
    localparam int DUTY_W  = TMR_W_P + FINE_W_P
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [1:0]         reg_sel,
    input  logic [TMR_W_P-1:0] reg_wdata,
    output logic               pwm_out,
    output logic [DUTY_W-1:0]  duty_active,
    output logic [DUTY_W-1:0]  time_base
);

    logic [TMR_W_P-1:0] period;
    logic [DUTY_W-1:0]  duty_buf;
    ctrl_t              ctrl;
    logic               en;
    logic [DUTY_W-1:0]  next_base;
    logic               tick;
    logic               wrap;

    pwm_regs #(.TMR_W_P(TMR_W_P), .FINE_W_P(FINE_W_P)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (reg_wr),
        .sel      (reg_sel),
        .wdata    (reg_wdata),
        .period   (period),
        .duty_buf (duty_buf),
        .ctrl     (ctrl)
    );

    assign en = (ctrl.mode == MODE_PWM);

    pwm_timebase #(.TMR_W_P(TMR_W_P), .FINE_W_P(FINE_W_P), .PS_W_P(PS_W_P)) u_tb (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .ps        (ctrl.ps),
        .period    (period),
        .base      (time_base),
        .next_base (next_base),
        .tick      (tick),
        .wrap      (wrap)
    );

    pwm_outlatch #(.DUTY_W(DUTY_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .tick      (tick),
        .wrap      (wrap),
        .next_base (next_base),
        .duty_buf  (duty_buf),
        .shadow    (duty_active),
        .pwm_q     (pwm_out)
    );

endmodule

// File: tb/tb_pwm_gen.sv
`timescale 1ns/1ps
module tb_pwm_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic       pwm_out;
    logic [9:0] duty_active;
    logic [9:0] time_base;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwm_gen dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .pwm_out(pwm_out),
        .duty_active(duty_active), .time_base(time_base)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int ratio_of(input int psel);
        return (psel == 0) ? 1 : (psel == 1) ? 4 : 16;
    endfunction

    // Strobe one write; returns at the negedge after the capturing edge.
    task automatic wr(input int sel, input int data);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 2'(sel); reg_wdata = 8'(data);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // Returns at the first sample after a period match edge.
    task automatic wait_wrap(input int pr, output bit ok);
        int prev;
        ok = 1'b0;
        prev = int'(time_base);
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (prev == pr * 4 + 3 && time_base == 10'd0) begin
                ok = 1'b1;
                break;
            end
            prev = int'(time_base);
        end
    endtask

    task automatic measure(input int pr, input int ratio, output int hi,
                           output int base_err, output bit end_ok);
        int n;
        int last;
        n = (pr + 1) * 4 * ratio;
        hi = 0; base_err = 0; last = 0;
        for (int i = 0; i < n; i++) begin
            if (pwm_out) hi++;
            if (int'(time_base) != i / ratio) base_err++;
            last = int'(time_base);
            @(negedge clk);
        end
        end_ok = (time_base == 10'd0) && (last == pr * 4 + 3);
    endtask

    task automatic run_cfg(input int pr, input int d, input int psel);
        int ratio, hi, berr, exp_hi, full;
        bit ok, eok;
        ratio = ratio_of(psel);
        full = (pr + 1) * 4;
        wr(2, 0);
        @(negedge clk);
        check(pwm_out == 1'b0 && time_base == 10'd0, "R9 off", int'(pwm_out), 0);
        wr(0, pr);
        wr(1, d >> 2);
        wr(2, (psel << 4) | (3 << 2) | (d & 3));
        check(pwm_out == 1'b0, "R9 low after enable", int'(pwm_out), 0);
        wait_wrap(pr, ok);
        check(ok, "R4 first match", int'(ok), 1);
        check(duty_active == 10'(d), "R5 shadow load", int'(duty_active), d);
        check(pwm_out == (d != 0), "R6 start level", int'(pwm_out), int'(d != 0));
        measure(pr, ratio, hi, berr, eok);
        check(berr == 0, "R3 base progression", berr, 0);
        check(eok, "R4 period length", int'(eok), 1);
        exp_hi = ((d < full) ? d : full) * ratio;
        if (d >= full)
            check(hi == exp_hi, "R8 full high", hi, exp_hi);
        else
            check(hi == exp_hi, "R7 high time", hi, exp_hi);
    endtask

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int hi, berr;
        bit ok, eok;
        repeat (3) @(negedge clk);
        check(pwm_out == 1'b0 && time_base == 10'd0 && duty_active == 10'd0,
              "R1 in reset", int'(pwm_out), 0);
        rst = 1'b0;
        @(negedge clk);
        check(pwm_out == 1'b0 && time_base == 10'd0 && duty_active == 10'd0,
              "R1 after release", int'(duty_active), 0);

        // R2 R7 R8: sweep duty over every prescale ratio and small periods
        for (int ps = 0; ps < 3; ps++)
            for (int pr = 0; pr < 4; pr++)
                for (int d = 0; d <= (pr + 1) * 4 + 1; d++)
                    run_cfg(pr, d, ps);
        run_cfg(1, 5, 3);
        run_cfg(255, 1023, 0);
        run_cfg(255, 1000, 0);
        run_cfg(255, 0, 0);

        // R5: a write inside a period waits for the next match
        run_cfg(3, 5, 0);
        wait_wrap(3, ok);
        fork
            measure(3, 1, hi, berr, eok);
            begin
                wr(1, 2);
                wr(2, (3 << 2) | 1);
                check(duty_active == 10'd5, "R5 hold mid period", int'(duty_active), 5);
            end
        join
        check(hi == 5, "R5 old duty used", hi, 5);
        check(duty_active == 10'd9, "R5 new duty latched", int'(duty_active), 9);
        measure(3, 1, hi, berr, eok);
        check(hi == 9, "R5 new duty used", hi, 9);

        // R5 R6: a write landing on the match edge misses that match
        run_cfg(0, 4, 0);
        while (time_base != 10'd3) @(negedge clk);
        reg_wr = 1'b1; reg_sel = 2'd1; reg_wdata = 8'd0;
        @(negedge clk);
        reg_wr = 1'b0;
        check(duty_active == 10'd4, "R5 write on match edge", int'(duty_active), 4);
        check(pwm_out == 1'b1, "R6 old duty sets", int'(pwm_out), 1);
        wait_wrap(0, ok);
        check(duty_active == 10'd0, "R5 zero latched", int'(duty_active), 0);
        measure(0, 1, hi, berr, eok);
        check(hi == 0, "R6 zero duty stays low", hi, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule